// File: doc/BRIEF.md
# Truncated-Range Counter and Divide-by-K Clock Divider

This block is a binary (or decimal-digit) counter whose natural range of 2^WIDTH states is cut short by a detector wired to its clear path. The count runs 0, 1, ..., K-1 and then returns to 0, so it counts modulo K for a compile-time modulus K below the full range. Taken from the top count bit, the same register serves as a frequency divider: the top bit repeats once every K enabled clocks.

Two clear styles are available through a parameter. In the synchronous style the detector recognises state K-1 and the register loads zero on the following edge. In the immediate style the detector recognises state K, but on the incremented value that is about to be stored, so K is discarded in the same cycle it is produced and never becomes a stable state. In both styles the detector combines only the bit positions that are 1 in the decoded value, through an active-low NAND term that matches the active-low clear. A parameter switches the register to BCD digits, in which case K and the decoded value are written in BCD.

Top module: `modk_counter`

## Requirements
- R1: While rst_n is low, count is 0, termCount is 0 and divOut is 0; reset is asynchronous.
- R2: With en low at a rising clock edge, count keeps its value.
- R3: With en high and count below K-1, count holds value+1 after the edge.
- R4: With en high and count equal to K-1, count is 0 after the edge; the stable sequence is 0 to K-1 and value K is never seen on count.
- R5: termCount is 1 exactly when en is 1 and count equals K-1.
- R6: divOut equals bit WIDTH-1 of count; when K-1 sets that bit, one rising edge of divOut occurs every K enabled clocks.
- R7: With BCD set, count is formed of WIDTH/4 four-bit digits (least significant digit in bits 3:0), each 0 to 9, and the count value is the decimal number they spell.
- R8: The immediate and the synchronous clear styles produce the same count sequence for the same K and en pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable; holds the count when low |
| count | output | WIDTH | Current count, binary or BCD digits |
| divOut | output | 1 | Divided output, top bit of count |
| termCount | output | 1 | High while enabled at state K-1 |

## Verification
The bench builds four copies side by side: WIDTH 4 with K 13 in both clear styles, WIDTH 5 with K 17 in the synchronous style, and WIDTH 8 BCD with K 95 in the immediate style. The two K 13 copies let every cycle compare the styles against each other, and K 13 gives partial decodes of three bits (13) and two bits (12). K 17 places the wrap just past a power of two so a decode of a single bit pair must not fire early, and the BCD copy exercises digit carries from 9 and a decimal wrap that the binary copies cannot reach.

// File: rtl/modk_pkg.sv
package modk_pkg;

  typedef enum logic {
    CLR_IMMEDIATE = 1'b0,
    CLR_SYNC      = 1'b1
  } clrStyle_e;

  typedef struct packed {
    logic advance;
    logic clear;
  } ctrlStrobe_t;

  function automatic logic [31:0] binToBcd(input int unsigned value);
    logic [31:0] packed_digits;
    int unsigned rest;
    packed_digits = '0;
    rest = value;
    for (int d = 0; d < 8; d++) begin
      packed_digits[4*d +: 4] = 4'(rest % 10);
      rest = rest / 10;
    end
    return packed_digits;
  endfunction

  function automatic int unsigned bcdToBin(input logic [31:0] digits);
    int unsigned acc;
    acc = 0;
    for (int d = 7; d >= 0; d--) begin
      acc = acc * 10 + int'(digits[4*d +: 4]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/modk_datapath.sv
module modk_datapath
  import modk_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter bit BCD   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  output logic [WIDTH-1:0]  countQ,
  output logic [WIDTH-1:0]  incValue
);

  localparam int DIGITS = WIDTH / 4;

  generate
    if (BCD) begin : g_bcdInc
      logic [DIGITS-1:0] carryIn;
      assign carryIn[0] = 1'b1;
      for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] digit;
        logic       atNine;
        assign digit  = countQ[4*g +: 4];
        assign atNine = (digit == 4'd9);
        assign incValue[4*g +: 4] = carryIn[g] ? (atNine ? 4'd0 : digit + 4'd1) : digit;
        if (g < DIGITS - 1) begin : g_carry
          assign carryIn[g+1] = carryIn[g] & atNine;
        end
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
          digit <= 4'd9); // R7
      end
    end else begin : g_binInc
      assign incValue = countQ + WIDTH'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (strobe.clear) begin
      countQ <= '0;
    end else if (strobe.advance) begin
      countQ <= incValue;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance && !strobe.clear |=> $stable(countQ)); // R2

endmodule

// File: rtl/modk_control.sv
module modk_control
  import modk_pkg::*;
#(
  parameter int        WIDTH       = 4,
  parameter int        MODULUS     = 13,
  parameter clrStyle_e CLEAR_STYLE = CLR_IMMEDIATE,
  parameter bit        BCD         = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WIDTH-1:0]  countQ,
  input  logic [WIDTH-1:0]  incValue,
  output ctrlStrobe_t       strobe,
  output logic              termCount
);

  localparam logic [WIDTH-1:0] TOP_ENC =
    BCD ? WIDTH'(binToBcd(MODULUS)) : WIDTH'(MODULUS);
  localparam logic [WIDTH-1:0] LAST_ENC =
    BCD ? WIDTH'(binToBcd(MODULUS - 1)) : WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] DETECT_PATTERN =
    (CLEAR_STYLE == CLR_SYNC) ? LAST_ENC : TOP_ENC;

  logic [WIDTH-1:0] detSrc;
  logic [WIDTH-1:0] hitBits;
  logic             clearN;

  assign detSrc = (CLEAR_STYLE == CLR_SYNC) ? countQ : incValue;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      if (DETECT_PATTERN[i]) begin : g_used
        assign hitBits[i] = detSrc[i];
      end else begin : g_ignored
        assign hitBits[i] = 1'b1;
      end
    end
  endgenerate

  assign clearN         = ~&hitBits;
  assign strobe.advance = en;
  assign strobe.clear   = en & ~clearN;
  assign termCount      = en && (countQ == LAST_ENC);

  AST_CLEAR_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clearN) |-> (countQ == LAST_ENC)); // R4
  AST_TC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    termCount |-> en); // R5

endmodule

// File: rtl/modk_counter.sv
module modk_counter
  import modk_pkg::*;
#(
  parameter int        WIDTH       = 4,
  parameter int        MODULUS     = 13,
  parameter clrStyle_e CLEAR_STYLE = CLR_IMMEDIATE,
  parameter bit        BCD         = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] count,
  output logic             divOut,
  output logic             termCount
);

  ctrlStrobe_t      strobe;
  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] incValue;
  int unsigned      countValue;

  modk_datapath #(.WIDTH(WIDTH), .BCD(BCD)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .countQ   (countQ),
    .incValue (incValue)
  );

  modk_control #(
    .WIDTH(WIDTH), .MODULUS(MODULUS), .CLEAR_STYLE(CLEAR_STYLE), .BCD(BCD)
  ) u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .countQ    (countQ),
    .incValue  (incValue),
    .strobe    (strobe),
    .termCount (termCount)
  );

  assign count      = countQ;
  assign divOut     = countQ[WIDTH-1];
  assign countValue = BCD ? bcdToBin(32'(countQ)) : 32'(countQ);

  AST_BELOW_MODULUS: assert property (@(posedge clk) disable iff (!rst_n)
    countValue < MODULUS); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !termCount) |=> countValue == $past(countValue) + 1); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    termCount |=> countValue == 0); // R4

endmodule

// File: tb/modk_counter_tb.sv
`timescale 1ns/1ps
module modk_counter_tb;
  import modk_pkg::*;

  localparam int K0 = 13;
  localparam int K2 = 17;
  localparam int K3 = 95;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] cnt0, cnt1;
  logic [4:0] cnt2;
  logic [7:0] cnt3;
  logic [3:0] div, tc;
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  modk_counter #(.WIDTH(4), .MODULUS(K0), .CLEAR_STYLE(CLR_IMMEDIATE), .BCD(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .count(cnt0), .divOut(div[0]), .termCount(tc[0]));
  modk_counter #(.WIDTH(4), .MODULUS(K0), .CLEAR_STYLE(CLR_SYNC), .BCD(1'b0)) u_dutSync (
    .clk(clk), .rst_n(rst_n), .en(en), .count(cnt1), .divOut(div[1]), .termCount(tc[1]));
  modk_counter #(.WIDTH(5), .MODULUS(K2), .CLEAR_STYLE(CLR_SYNC), .BCD(1'b0)) u_dutWide (
    .clk(clk), .rst_n(rst_n), .en(en), .count(cnt2), .divOut(div[2]), .termCount(tc[2]));
  modk_counter #(.WIDTH(8), .MODULUS(K3), .CLEAR_STYLE(CLR_IMMEDIATE), .BCD(1'b1)) u_dutBcd (
    .clk(clk), .rst_n(rst_n), .en(en), .count(cnt3), .divOut(div[3]), .termCount(tc[3]));

  int modulus[4] = '{K0, K0, K2, K3};
  int widthOf[4] = '{4, 4, 5, 8};
  bit isBcd[4]   = '{1'b0, 1'b0, 1'b0, 1'b1};
  int model[4];
  int enEdges[4];
  bit seenRise[4];
  logic [3:0] prevDiv;

  function automatic int encodeValue(input int v, input bit bcd);
    int r;
    int rest;
    if (!bcd) return v;
    r = 0;
    rest = v;
    for (int d = 0; d < 8; d++) begin
      r = r | ((rest % 10) << (4 * d));
      rest = rest / 10;
    end
    return r;
  endfunction

  function automatic int countOf(input int idx);
    case (idx)
      0: return int'(cnt0);
      1: return int'(cnt1);
      2: return int'(cnt2);
      default: return int'(cnt3);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic resetModels();
    for (int i = 0; i < 4; i++) begin
      model[i] = 0;
      enEdges[i] = 0;
      seenRise[i] = 1'b0;
    end
    prevDiv = '0;
  endtask

  task automatic checkReset();
    for (int i = 0; i < 4; i++) begin
      chk(countOf(i) == 0, "R1 count", countOf(i), 0);
      chk(tc[i] == 1'b0, "R1 termCount", int'(tc[i]), 0);
      chk(div[i] == 1'b0, "R1 divOut", int'(div[i]), 0);
    end
  endtask

  task automatic oneCycle(input bit enVal);
    int enc;
    int act;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      enc = encodeValue(model[i], isBcd[i]);
      act = countOf(i);
      chk(act == enc, "R3/R4 count", act, enc);
      chk(div[i] == enc[widthOf[i]-1], "R6 divOut", int'(div[i]), int'(enc[widthOf[i]-1]));
      if (isBcd[i]) begin
        for (int d = 0; d < widthOf[i] / 4; d++)
          chk(((act >> (4 * d)) & 15) <= 9, "R7 digit", (act >> (4 * d)) & 15, 9);
      end
      if (div[i] && !prevDiv[i]) begin
        if (seenRise[i]) chk(enEdges[i] == modulus[i], "R6 period", enEdges[i], modulus[i]);
        seenRise[i] = 1'b1;
        enEdges[i] = 0;
      end
      prevDiv[i] = div[i];
    end
    chk(cnt0 == cnt1, "R8 styles agree", int'(cnt0), int'(cnt1));
    en = enVal;
    #1;
    for (int i = 0; i < 4; i++) begin
      chk(tc[i] == (enVal && model[i] == modulus[i] - 1), "R5 termCount",
          int'(tc[i]), int'(enVal && model[i] == modulus[i] - 1));
      if (enVal) begin
        model[i] = (model[i] + 1) % modulus[i];
        enEdges[i]++;
      end
      // R2: with en low the model stays, so the next compare checks the hold
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    resetModels();
    repeat (3) @(negedge clk);
    #1 checkReset();
    rst_n = 1'b1;
    // directed: free run through several wraps of every copy
    repeat (300) oneCycle(1'b1);
    // random enable pattern
    repeat (2500) oneCycle(($urandom % 10) < 7);
    // directed: long hold, R2
    repeat (25) oneCycle(1'b0);
    // stop right at K-1 of the binary copies then hold
    while (model[0] != K0 - 1) oneCycle(1'b1);
    repeat (5) oneCycle(1'b0);
    oneCycle(1'b1);
    // mid-run asynchronous reset, R1
    repeat (7) oneCycle(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b1;
    #1 checkReset();
    @(negedge clk);
    #1 checkReset();
    resetModels();
    rst_n = 1'b1;
    en = 1'b0;
    repeat (400) oneCycle(1'b1);
    repeat (1000) oneCycle(($urandom % 4) != 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule